// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

The block paints one hardware cursor over a 4:2:2 pixel stream that already carries video and graphics. Each incoming pixel arrives with its horizontal and line counters, a luma byte and a chroma byte. The chroma byte holds Cb on even pixels and Cr on odd pixels. The cursor image is a fixed store of 1024 two-bit pixels. A shape select reads that store as one of five rectangles, from tall and narrow to wide and flat. Each two-bit cursor pixel picks an entry from a four-entry colour table. The entry's transparency code sets how strongly the cursor colour replaces the background, in one of four levels.

A host loads the image store and the colour table through two simple write ports. It places the cursor with signed X/Y position inputs. The cursor may hang off any edge of the screen; only its visible part is drawn. Every pixel, covered or not, leaves the block exactly two clocks after it entered. The overlay therefore drops into an existing display pipeline as a fixed delay.

Top module: `cursor_overlay_mixer`

## Requirements
- R1: A pixel presented on the inputs in cycle n appears on the outputs in cycle n+2, and outValid in cycle n+2 equals inValid in cycle n, whether or not the pixel is covered.
- R2: A host write with bmpWe high stores bmpData at image location bmpAddr (0 to 1023) at the clock edge. Later pixels that map to that location use the new value as their colour table index.
- R3: shapeSel value s in 0..4 selects a cursor of width 8<<s and height 128>>s. The image location for a covered pixel is (line - curY) * width + (x - curX). shapeSel values 5 to 7 hide the cursor, so all pixels pass through.
- R4: A pixel outside the cursor rectangle leaves with its luma unchanged.
- R5: A colour table write with clutWe high stores clutData into entry clutIdx. The fields are Y in bits 15:10, Cb in bits 9:6, Cr in bits 5:2 and the transparency code in bits 1:0. Before mixing, Y is widened to 8 bits as {Y, Y[5:4]}, and each chroma field is widened as {C, C}.
- R6: Each output component is floor((bg*(4-w) + cur*w) / 4). Here w is 0, 1, 2 or 4 for transparency codes 0, 1, 2 and 3, so code 0 leaves the background untouched and code 3 replaces it.
- R7: The chroma byte of pixel x is mixed with the Cb field (x even) or the Cr field (x odd) of the entry chosen by pixel x with bit 0 cleared. If that even pixel lies outside the cursor, the chroma passes through, even when pixel x itself is covered.
- R8: curX and curY are two's complement values of CNT_W+1 bits. A cursor with negative coordinates, or one reaching past the largest counter value, draws exactly its pixels that fall on the counters.
- R9: After reset the outputs are zero, and the image store and colour table hold zeros. Every pixel therefore passes through until the host loads a non-zero transparency code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input pixel qualifier, carried through the pipeline |
| inX | input | CNT_W | Horizontal pixel counter |
| inLine | input | CNT_W | Line counter |
| inY | input | 8 | Background luma |
| inC | input | 8 | Background chroma (Cb on even x, Cr on odd x) |
| curX | input | CNT_W+1 | Signed cursor left edge |
| curY | input | CNT_W+1 | Signed cursor top line |
| shapeSel | input | 3 | Cursor shape code |
| bmpWe | input | 1 | Image store write enable |
| bmpAddr | input | 10 | Image store write location |
| bmpData | input | 2 | Image store write value |
| clutWe | input | 1 | Colour table write enable |
| clutIdx | input | 2 | Colour table entry |
| clutData | input | 16 | Colour table entry value |
| outValid | output | 1 | Output pixel qualifier |
| outY | output | 8 | Mixed luma |
| outC | output | 8 | Mixed chroma |

## Verification
The bench builds the block with CNT_W set to 10, so the counters run from 0 to 1023. At that width the last columns and lines of the counter range are cheap to reach. A position near 1000 places part of the cursor beyond the counter range, and a negative position hides its top-left corner, so both clipping directions are exercised in short runs. The shape code keeps its full three-bit width, which lets the bench try all five shapes and the three unused codes that hide the cursor.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  localparam int BMP_DEPTH  = 1024;
  localparam int BMP_AW     = $clog2(BMP_DEPTH);
  localparam int IDX_W      = 2;
  localparam int CLUT_DEPTH = 1 << IDX_W;
  localparam int NUM_SHAPES = 5;
  localparam int SHAPE_W    = 3;
  localparam int MIN_WLOG   = 3;
  localparam int PIX_W      = 8;

  typedef struct packed {
    logic [5:0] y;
    logic [3:0] u;
    logic [3:0] v;
    logic [1:0] t;
  } clutEntry_t;

  // control-to-datapath strobes, registered in stage one
  typedef struct packed {
    logic             lumaHit;
    logic [IDX_W-1:0] lumaIdx;
    logic             chromaHit;
    logic [IDX_W-1:0] chromaIdx;
    logic             oddPix;
  } cursorStrobe_t;

  function automatic logic [PIX_W-1:0] widen6(input logic [5:0] f);
    return {f, f[5:4]};
  endfunction

  function automatic logic [PIX_W-1:0] widen4(input logic [3:0] f);
    return {f, f};
  endfunction

  function automatic logic [PIX_W-1:0] mixLevel(input logic [PIX_W-1:0] bg,
                                                 input logic [PIX_W-1:0] fg,
                                                 input logic [1:0] lvl);
    logic [PIX_W+1:0] acc;
    unique case (lvl)
      2'd0:    acc = {bg, 2'b00};
      2'd1:    acc = {2'b00, bg} + {1'b0, bg, 1'b0} + {2'b00, fg};
      2'd2:    acc = {1'b0, bg, 1'b0} + {1'b0, fg, 1'b0};
      default: acc = {fg, 2'b00};
    endcase
    return acc[PIX_W+1:2];
  endfunction

endpackage

// File: rtl/cursor_locate.sv
module cursor_locate
  import cursor_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0]  pixX,
  input  logic [CNT_W-1:0]  pixLine,
  input  logic [CNT_W:0]    curX,
  input  logic [CNT_W:0]    curY,
  input  logic [2:0]        widthLog,
  input  logic              shapeOk,
  output logic              hit,
  output logic [BMP_AW-1:0] addr
);

  localparam int RW = CNT_W + 2;

  logic [RW-1:0] relX, relY;
  logic [3:0]    heightLog;
  logic          insideX, insideY;

  assign relX = {2'b00, pixX} - {curX[CNT_W], curX};
  assign relY = {2'b00, pixLine} - {curY[CNT_W], curY};
  assign heightLog = 4'(BMP_AW) - {1'b0, widthLog};

  assign insideX = !relX[RW-1] && ((relX >> widthLog) == '0);
  assign insideY = !relY[RW-1] && ((relY >> heightLog) == '0);

  assign hit  = shapeOk && insideX && insideY;
  assign addr = BMP_AW'((relY << widthLog) | relX);

endmodule

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   inX,
  input  logic [CNT_W-1:0]   inLine,
  input  logic [CNT_W:0]     curX,
  input  logic [CNT_W:0]     curY,
  input  logic [SHAPE_W-1:0] shapeSel,
  input  logic               bmpWe,
  input  logic [BMP_AW-1:0]  bmpAddr,
  input  logic [IDX_W-1:0]   bmpData,
  output cursorStrobe_t      strobe
);

  logic [IDX_W-1:0] bmpMem [BMP_DEPTH];

  logic       shapeOk;
  logic [2:0] widthLog;
  logic [1:0]             probeHit;
  logic [BMP_AW-1:0]      probeAddr [2];
  logic [CNT_W-1:0]       probeX    [2];

  assign shapeOk  = shapeSel < SHAPE_W'(NUM_SHAPES);
  assign widthLog = 3'(shapeSel + 3'(MIN_WLOG));

  // probe 0 serves luma at the pixel itself, probe 1 serves chroma
  // at the co-sited even pixel of the pair
  assign probeX[0] = inX;
  assign probeX[1] = {inX[CNT_W-1:1], 1'b0};

  for (genvar p = 0; p < 2; p++) begin : g_probe
    cursor_locate #(.CNT_W(CNT_W)) u_locate (
      .pixX    (probeX[p]),
      .pixLine (inLine),
      .curX    (curX),
      .curY    (curY),
      .widthLog(widthLog),
      .shapeOk (shapeOk),
      .hit     (probeHit[p]),
      .addr    (probeAddr[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BMP_DEPTH; i++) bmpMem[i] <= '0;
    end else if (bmpWe) begin
      bmpMem[bmpAddr] <= bmpData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe <= '0;
    end else begin
      strobe.lumaHit   <= probeHit[0];
      strobe.lumaIdx   <= bmpMem[probeAddr[0]];
      strobe.chromaHit <= probeHit[1];
      strobe.chromaIdx <= bmpMem[probeAddr[1]];
      strobe.oddPix    <= inX[0];
    end
  end

  assert_bmp_write_R2 : assert property (@(posedge clk) disable iff (!rstN)
    bmpWe |=> bmpMem[$past(bmpAddr)] == $past(bmpData));

  assert_hidden_shape_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (shapeSel >= SHAPE_W'(NUM_SHAPES)) |=> (!strobe.lumaHit && !strobe.chromaHit));

  assert_even_pair_R7 : assert property (@(posedge clk) disable iff (!rstN)
    !inX[0] |=> (strobe.chromaHit == strobe.lumaHit) &&
                (!strobe.lumaHit || strobe.chromaIdx == strobe.lumaIdx));

endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inY,
  input  logic [PIX_W-1:0] inC,
  input  logic             clutWe,
  input  logic [IDX_W-1:0] clutIdx,
  input  logic [15:0]      clutData,
  input  cursorStrobe_t    strobe,
  output logic             outValid,
  output logic [PIX_W-1:0] outY,
  output logic [PIX_W-1:0] outC
);

  clutEntry_t clutMem [CLUT_DEPTH];

  logic             validQ;
  logic [PIX_W-1:0] yQ, cQ;
  logic [1:0]       warmCnt;

  logic [5:0]       lumaY6;
  logic [1:0]       lumaT, chromaT;
  logic [3:0]       chromaF4;
  logic [PIX_W-1:0] mixY, mixC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CLUT_DEPTH; i++) clutMem[i] <= '0;
    end else if (clutWe) begin
      clutMem[clutIdx] <= clutEntry_t'(clutData);
    end
  end

  // stage one: background pixel aligned with the registered strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      yQ     <= '0;
      cQ     <= '0;
    end else begin
      validQ <= inValid;
      yQ     <= inY;
      cQ     <= inC;
    end
  end

  assign lumaY6   = clutMem[strobe.lumaIdx].y;
  assign lumaT    = clutMem[strobe.lumaIdx].t;
  assign chromaT  = clutMem[strobe.chromaIdx].t;
  assign chromaF4 = strobe.oddPix ? clutMem[strobe.chromaIdx].v
                                  : clutMem[strobe.chromaIdx].u;

  assign mixY = strobe.lumaHit   ? mixLevel(yQ, widen6(lumaY6), lumaT)     : yQ;
  assign mixC = strobe.chromaHit ? mixLevel(cQ, widen4(chromaF4), chromaT) : cQ;

  // stage two: mixed pixel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outY     <= '0;
      outC     <= '0;
    end else begin
      outValid <= validQ;
      outY     <= mixY;
      outC     <= mixC;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  assert_valid_delay_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2) |-> outValid == $past(inValid, 2));

  assert_uncovered_luma_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt != 2'd0 && !strobe.lumaHit) |=> outY == $past(yQ));

  assert_opaque_luma_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lumaHit && lumaT == 2'd3) |=> outY[PIX_W-1:2] == $past(lumaY6));

  assert_clear_level_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.chromaHit && chromaT == 2'd0) |=> outC == $past(cQ));

endmodule

// File: rtl/cursor_overlay_mixer.sv
module cursor_overlay_mixer
  import cursor_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [CNT_W-1:0]   inX,
  input  logic [CNT_W-1:0]   inLine,
  input  logic [PIX_W-1:0]   inY,
  input  logic [PIX_W-1:0]   inC,
  input  logic [CNT_W:0]     curX,
  input  logic [CNT_W:0]     curY,
  input  logic [SHAPE_W-1:0] shapeSel,
  input  logic               bmpWe,
  input  logic [BMP_AW-1:0]  bmpAddr,
  input  logic [IDX_W-1:0]   bmpData,
  input  logic               clutWe,
  input  logic [IDX_W-1:0]   clutIdx,
  input  logic [15:0]        clutData,
  output logic               outValid,
  output logic [PIX_W-1:0]   outY,
  output logic [PIX_W-1:0]   outC
);

  cursorStrobe_t strobe;

  cursor_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inX     (inX),
    .inLine  (inLine),
    .curX    (curX),
    .curY    (curY),
    .shapeSel(shapeSel),
    .bmpWe   (bmpWe),
    .bmpAddr (bmpAddr),
    .bmpData (bmpData),
    .strobe  (strobe)
  );

  cursor_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inY     (inY),
    .inC     (inC),
    .clutWe  (clutWe),
    .clutIdx (clutIdx),
    .clutData(clutData),
    .strobe  (strobe),
    .outValid(outValid),
    .outY    (outY),
    .outC    (outC)
  );

endmodule

// File: tb/sim_cursor_overlay_mixer.sv
`timescale 1ns/1ps
module sim_cursor_overlay_mixer;

  localparam int CW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [CW-1:0] inX = '0, inLine = '0;
  logic [7:0] inY = '0, inC = '0;
  logic [CW:0] curX = '0, curY = '0;
  logic [2:0] shapeSel = 3'd2;
  logic bmpWe = 1'b0;
  logic [9:0] bmpAddr = '0;
  logic [1:0] bmpData = '0;
  logic clutWe = 1'b0;
  logic [1:0] clutIdx = '0;
  logic [15:0] clutData = '0;
  logic outValid;
  logic [7:0] outY, outC;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [1:0]  mBmp [1024];
  logic [15:0] mClut [4];
  int mShape = 2, mCx = 0, mCy = 0;

  always #2.5 clk = ~clk;

  cursor_overlay_mixer #(.CNT_W(CW)) u0 (.*);

  task automatic expectVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int idxAt(int x, int l);
    int w, h, rx, ry;
    if (mShape > 4) return -1;
    w = 8 << mShape; h = 1024 / w;
    rx = x - mCx; ry = l - mCy;
    if (rx < 0 || ry < 0 || rx >= w || ry >= h) return -1;
    return mBmp[ry * w + rx];
  endfunction

  function automatic int mix(int b, int f, int t);
    int w = (t == 3) ? 4 : t;
    return (b * (4 - w) + f * w) / 4;
  endfunction

  function automatic int expY(int x, int l, int bg);
    int i = idxAt(x, l);
    logic [15:0] e;
    int y6;
    if (i < 0) return bg;
    e = mClut[i]; y6 = e[15:10];
    return mix(bg, (y6 << 2) | (y6 >> 4), e[1:0]);
  endfunction

  function automatic int expC(int x, int l, int bg);
    int i = idxAt(x & ~1, l);
    logic [15:0] e;
    int f;
    if (i < 0) return bg;
    e = mClut[i];
    f = (x & 1) ? e[5:2] : e[9:6];
    return mix(bg, (f << 4) | f, e[1:0]);
  endfunction

  task automatic place(int s, int cx, int cy);
    @(negedge clk);
    shapeSel = 3'(s); curX = (CW+1)'(cx); curY = (CW+1)'(cy);
    mShape = s; mCx = cx; mCy = cy;
  endtask

  task automatic writeBmp(int a, int v);
    @(negedge clk);
    bmpWe = 1'b1; bmpAddr = 10'(a); bmpData = 2'(v); mBmp[a] = 2'(v);
    @(negedge clk);
    bmpWe = 1'b0;
  endtask

  task automatic writeClut(int i, logic [15:0] v);
    @(negedge clk);
    clutWe = 1'b1; clutIdx = 2'(i); clutData = v; mClut[i] = v;
    @(negedge clk);
    clutWe = 1'b0;
  endtask

  task automatic probe(string tag, int x, int l, int y, int c);
    @(negedge clk);
    inValid = 1'b1; inX = CW'(x); inLine = CW'(l); inY = 8'(y); inC = 8'(c);
    @(negedge clk);
    @(negedge clk);
    expectVal({tag, " luma"}, outY, expY(x, l, y));
    expectVal({tag, " chroma"}, outC, expC(x, l, c));
  endtask

  task automatic testReset();
    expectVal("R9 outValid after reset", outValid, 0);
    expectVal("R9 outY after reset", outY, 0);
    expectVal("R9 outC after reset", outC, 0);
    place(2, 0, 0);
    probe("R9 cleared tables pass", 3, 3, 8'h37, 8'hC4);
    probe("R9 cleared tables pass", 0, 0, 8'h80, 8'h11);
  endtask

  task automatic loadTables();
    writeClut(0, {6'h3F, 4'hF, 4'hF, 2'd0});
    writeClut(1, {6'h08, 4'h3, 4'hC, 2'd1});
    writeClut(2, {6'h2A, 4'hA, 4'h5, 2'd2});
    writeClut(3, {6'h15, 4'h6, 4'h9, 2'd3});
    for (int a = 0; a < 1024; a++) writeBmp(a, (a ^ (a >> 3) ^ (a >> 6)) & 3);
  endtask

  task automatic testBitmapWrite();
    place(2, 20, 10);
    writeBmp(0, 3);
    probe("R2 opaque entry", 20, 10, 8'h10, 8'h20);
    expectVal("R5 widened Y of entry 3", outY, 8'h55);
    expectVal("R5 widened Cb of entry 3", outC, 8'h66);
    writeBmp(0, 2);
    probe("R2 rewritten entry", 20, 10, 8'h10, 8'h20);
    expectVal("R6 half level luma", outY, 8'h5D);
  endtask

  task automatic testShapes();
    for (int s = 0; s < 5; s++) begin
      int w = 8 << s;
      int h = 1024 / w;
      place(s, 20, 10);
      probe("R3 top-left", 20, 10, 8'h40, 8'h90);
      probe("R3 bottom-right", 20 + w - 1, 10 + h - 1, 8'h41, 8'h91);
      probe("R3 interior", 20 + w / 2, 10 + h / 3, 8'h42, 8'h92);
      probe("R4 right of box", 20 + w, 10, 8'h43, 8'h93);
      probe("R4 below box", 20, 10 + h, 8'h44, 8'h94);
      probe("R4 left of box", 19, 12, 8'h45, 8'h95);
    end
  endtask

  task automatic testHiddenCodes();
    for (int s = 5; s < 8; s++) begin
      place(s, 20, 10);
      probe("R3 unused code hides", 21, 11, 8'h6A, 8'h7B);
      expectVal("R3 unused code luma", outY, 8'h6A);
    end
  endtask

  task automatic testLevels();
    place(2, 0, 0);
    for (int i = 0; i < 4; i++) writeBmp(i, i);
    for (int i = 0; i < 4; i++) probe("R6 level", i, 0, 8'hE0, 8'h30);
  endtask

  task automatic testOffscreen();
    place(2, -5, -3);
    probe("R8 negative corner", 0, 0, 8'h22, 8'h33);
    probe("R8 negative inside", 26, 28, 8'h23, 8'h34);
    probe("R8 negative outside", 27, 28, 8'h24, 8'h35);
    place(4, 1000, 1020);
    probe("R8 past counter top", 1023, 1023, 8'h25, 8'h36);
    probe("R8 before far box", 999, 1023, 8'h26, 8'h37);
  endtask

  task automatic testChroma();
    place(2, 21, 10);
    writeBmp(0, 3);
    probe("R7 odd first column", 21, 10, 8'h50, 8'h60);
    expectVal("R7 partner outside keeps chroma", outC, 8'h60);
    writeBmp(1, 3);
    probe("R7 even column", 22, 10, 8'h51, 8'h61);
    probe("R7 odd uses even partner", 23, 10, 8'h52, 8'h62);
  endtask

  task automatic testLatency();
    int xs[8];
    int ys[8];
    int cs[8];
    int vs[8];
    place(2, 4, 4);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        expectVal("R1 stream luma", outY, expY(xs[k-2], 5, ys[k-2]));
        expectVal("R1 stream chroma", outC, expC(xs[k-2], 5, cs[k-2]));
        expectVal("R1 stream valid", outValid, vs[k-2]);
      end
      if (k < 8) begin
        xs[k] = k; ys[k] = 16 * k + 3; cs[k] = 255 - 9 * k; vs[k] = k % 3 != 1;
        inX = CW'(xs[k]); inLine = CW'(5); inY = 8'(ys[k]); inC = 8'(cs[k]);
        inValid = 1'(vs[k]);
      end
    end
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) mBmp[a] = '0;
    for (int i = 0; i < 4; i++) mClut[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    loadTables();
    testBitmapWrite();
    testShapes();
    testHiddenCodes();
    testLevels();
    testOffscreen();
    testChroma();
    testLatency();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule